// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of an 8-bit controller's multiplexed external memory bus: an active-high address-latch strobe (`ale`) and an active-low program-fetch strobe (`psen_n`). It has its own machine-cycle slot counter, which splits every machine cycle into twelve oscillator clocks. A small state machine tracks whether the current machine cycle is an ordinary fetch cycle or one of the two cycles of an external data transfer. The strobes are decoded from the slot and the cycle state, and both strobes are registered.

The sequencer supplies four status inputs: an external data request, a code-table read, external-execution mode and a software ALE-disable bit. All four are sampled once per machine cycle, on the clock edge that leaves the last slot. The `mc_sync` output marks that last slot, so the sequencer knows when to present the inputs. A data request starts a two-cycle access. In the second cycle of that access, the first address-latch pulse and both fetch pulses are suppressed. With the ALE-disable bit set and execution from internal memory, the address-latch strobe is parked high except in cycles that belong to a data move or a code-table read.

States and transitions:
- `CYC_FETCH`: the ordinary cycle. It goes to `CYC_XD_ADDR` when a request is sampled, and otherwise stays in `CYC_FETCH`.
- `CYC_XD_ADDR`: the first data-access cycle. It always goes to `CYC_XD_XFER`.
- `CYC_XD_XFER`: the second data-access cycle. It goes to `CYC_XD_ADDR` when a new request is sampled, and otherwise returns to `CYC_FETCH`.

Top module: `xbus_strobe_gen`

## Requirements
- R1: In a fetch cycle with the ALE-disable bit clear, `ale` is high during slots 0-1 and 6-7 of the 12-slot machine cycle and low in all other slots. This gives two pulses per machine cycle, each two clocks wide.
- R2: While `ext_exec` is sampled high, `psen_n` is low during slots 3-5 and 9-11 and high in all other slots. `ale` and `psen_n` are never active together.
- R3: While `ext_exec` is sampled low, `psen_n` stays high in every slot.
- R4: A sampled `xdata_req` in a fetch cycle starts a two-cycle data access. The first cycle has unchanged strobes.
- R5: In the second cycle of a data access, the slot 0-1 `ale` pulse is dropped (`ale` is low), the slot 6-7 pulse remains, and `psen_n` stays high. A request sampled at the start of this cycle is ignored. A request sampled at its end starts a new access at once.
- R6: With `ale_off` set and `ext_exec` low, `ale` is held high through fetch cycles without `code_rd`. It pulses as in R1 and R5 in code-read cycles and in both data-access cycles.
- R7: With `ext_exec` high, `ale_off` has no effect on `ale`.
- R8: The four status inputs act only when sampled on the edge leaving slot 11. Changes during a cycle do not alter that cycle's strobes or the next cycle's type.
- R9: While reset is asserted, `ale` = 0, `psen_n` = 1 and `mc_sync` = 1. The first cycle after release is a fetch cycle.
- R10: `mc_sync` is high during slot 11 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xdata_req | input | 1 | External data access requested for the next cycle |
| code_rd | input | 1 | Next cycle is a code-table read |
| ext_exec | input | 1 | Program executes from external memory |
| ale_off | input | 1 | Software ALE-disable bit |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program fetch strobe, active low |
| mc_sync | output | 1 | High in the last slot of a machine cycle (input sample point) |

## Verification
The main function is driven with a sequence of machine cycles that each hold one combination of request, code-read, execution mode and disable bit. Every slot of each cycle is captured and compared against a full 12-slot pattern.

Internal and external execution are contrasted to tell apart the PSEN gating. Isolated and back-to-back data requests separate the fetch, address and transfer cycles, and show whether a request arriving during the transfer cycle is handled correctly. Disable-bit cycles with and without code or data activity, in both execution modes, show whether ALE is parked high or pulsing.

Directed runs toggle the inputs in mid-cycle to confirm that they are sampled only at the cycle boundary, and apply reset inside a transfer cycle.

// File: rtl/xbus_strobe_pkg.sv
package xbus_strobe_pkg;

    // Machine-cycle type tracked by the cycle state machine
    typedef enum logic [1:0] {
        CYC_FETCH   = 2'd0,
        CYC_XD_ADDR = 2'd1,
        CYC_XD_XFER = 2'd2
    } cyc_kind_e;

    // Per-cycle state: type plus the status flags latched at the boundary
    typedef struct packed {
        cyc_kind_e kind;
        logic      ext_exec;
        logic      ale_off;
        logic      code_rd;
    } cyc_info_t;

    localparam cyc_info_t CYC_RESET = '{kind: CYC_FETCH, ext_exec: 1'b0,
                                        ale_off: 1'b0, code_rd: 1'b0};

endpackage

// File: rtl/xbus_slot_counter.sv
module xbus_slot_counter #(
    parameter int CYCLE_LEN = 12,
    localparam int SW = $clog2(CYCLE_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] slot_q,
    output logic [SW-1:0] slot_nxt,
    output logic          last_slot
);

    localparam logic [SW-1:0] LAST = SW'(CYCLE_LEN - 1);

    assign last_slot = (slot_q == LAST);

    always_comb begin
        slot_nxt = last_slot ? '0 : slot_q + SW'(1);
    end

    // Reset parks on the last slot so the first edge opens a full cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= LAST;
        else        slot_q <= slot_nxt;
    end

endmodule

// File: rtl/xbus_cycle_fsm.sv
module xbus_cycle_fsm
    import xbus_strobe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      last_slot,
    input  logic      xdata_req,
    input  logic      code_rd,
    input  logic      ext_exec,
    input  logic      ale_off,
    output cyc_info_t cyc_q,
    output cyc_info_t cyc_nxt
);

    // Next-state process: decisions are taken only at the cycle boundary
    always_comb begin
        cyc_nxt = cyc_q;
        if (last_slot) begin
            cyc_nxt.ext_exec = ext_exec;
            cyc_nxt.ale_off  = ale_off;
            cyc_nxt.code_rd  = code_rd;
            unique case (cyc_q.kind)
                CYC_FETCH:   cyc_nxt.kind = xdata_req ? CYC_XD_ADDR : CYC_FETCH;
                CYC_XD_ADDR: cyc_nxt.kind = CYC_XD_XFER;
                CYC_XD_XFER: cyc_nxt.kind = xdata_req ? CYC_XD_ADDR : CYC_FETCH;
                default:     cyc_nxt.kind = CYC_FETCH;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc_q <= CYC_RESET;
        else        cyc_q <= cyc_nxt;
    end

endmodule

// File: rtl/xbus_strobe_out.sv
module xbus_strobe_out
    import xbus_strobe_pkg::*;
#(
    parameter int CYCLE_LEN = 12,
    parameter int ALE_W     = 2,
    localparam int SW   = $clog2(CYCLE_LEN),
    localparam int HALF = CYCLE_LEN / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] slot_nxt,
    input  cyc_info_t     cyc_nxt,
    output logic          ale,
    output logic          psen_n
);

    logic          first_half;
    logic [SW-1:0] pos;
    logic          ale_slot;
    logic          psen_slot;
    logic          ale_win;
    logic          psen_win;
    logic          data_instr;
    logic          ale_gate;
    logic          ale_d;
    logic          psen_d;

    // Position within a half cycle; each half carries one strobe pair
    assign first_half = (slot_nxt < SW'(HALF));
    assign pos        = first_half ? slot_nxt : slot_nxt - SW'(HALF);
    assign ale_slot   = (pos < SW'(ALE_W));
    assign psen_slot  = (pos > SW'(ALE_W));

    // Output decode per cycle state, evaluated for the slot about to start
    always_comb begin
        ale_win    = 1'b0;
        psen_win   = 1'b0;
        data_instr = 1'b0;
        unique case (cyc_nxt.kind)
            CYC_FETCH: begin
                ale_win  = ale_slot;
                psen_win = psen_slot;
            end
            CYC_XD_ADDR: begin
                ale_win    = ale_slot;
                psen_win   = psen_slot;
                data_instr = 1'b1;
            end
            CYC_XD_XFER: begin
                ale_win    = ale_slot && !first_half;
                psen_win   = 1'b0;
                data_instr = 1'b1;
            end
            default: begin
                ale_win  = 1'b0;
                psen_win = 1'b0;
            end
        endcase
        ale_gate = cyc_nxt.ext_exec || !cyc_nxt.ale_off || data_instr || cyc_nxt.code_rd;
        ale_d    = ale_gate ? ale_win : 1'b1;
        psen_d   = psen_win && cyc_nxt.ext_exec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale    <= 1'b0;
            psen_n <= 1'b1;
        end else begin
            ale    <= ale_d;
            psen_n <= !psen_d;
        end
    end

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_strobe_pkg::*;
#(
    parameter int CYCLE_LEN = 12,
    parameter int ALE_W     = 2,
    localparam int SW = $clog2(CYCLE_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xdata_req,
    input  logic code_rd,
    input  logic ext_exec,
    input  logic ale_off,
    output logic ale,
    output logic psen_n,
    output logic mc_sync
);

    logic [SW-1:0] slot_q;
    logic [SW-1:0] slot_nxt;
    logic          last_slot;
    cyc_info_t     cyc_q;
    cyc_info_t     cyc_nxt;

    xbus_slot_counter #(.CYCLE_LEN(CYCLE_LEN)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_q    (slot_q),
        .slot_nxt  (slot_nxt),
        .last_slot (last_slot)
    );

    xbus_cycle_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_slot (last_slot),
        .xdata_req (xdata_req),
        .code_rd   (code_rd),
        .ext_exec  (ext_exec),
        .ale_off   (ale_off),
        .cyc_q     (cyc_q),
        .cyc_nxt   (cyc_nxt)
    );

    xbus_strobe_out #(.CYCLE_LEN(CYCLE_LEN), .ALE_W(ALE_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_nxt (slot_nxt),
        .cyc_nxt  (cyc_nxt),
        .ale      (ale),
        .psen_n   (psen_n)
    );

    assign mc_sync = last_slot;

endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk
    import xbus_strobe_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      ale,
    input logic      psen_n,
    input logic      mc_sync,
    input cyc_info_t cyc
);

    AST_ALE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale); // R1

    AST_NO_STROBE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && !psen_n)); // R2

    AST_INT_PSEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc.ext_exec |-> psen_n); // R3

    AST_ADDR_TO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc.kind == CYC_XD_ADDR && mc_sync) |=> (cyc.kind == CYC_XD_XFER)); // R4

    AST_XFER_NO_PSEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc.kind == CYC_XD_XFER) |-> psen_n); // R5

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_sync |=> $stable(cyc)); // R8

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mc_sync |=> !mc_sync); // R10

endmodule

bind xbus_strobe_gen xbus_strobe_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale     (ale),
    .psen_n  (psen_n),
    .mc_sync (mc_sync),
    .cyc     (cyc_q)
);

// File: tb/xbus_strobe_gen_bench.sv
module xbus_strobe_gen_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xdata_req = 1'b0;
    logic code_rd = 1'b0;
    logic ext_exec = 1'b0;
    logic ale_off = 1'b0;
    logic ale;
    logic psen_n;
    logic mc_sync;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xbus_strobe_gen u_xbus_strobe_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .xdata_req (xdata_req),
        .code_rd   (code_rd),
        .ext_exec  (ext_exec),
        .ale_off   (ale_off),
        .ale       (ale),
        .psen_n    (psen_n),
        .mc_sync   (mc_sync)
    );

    // Row: {xdata_req, code_rd, ext_exec, ale_off, ale[11:0], psen_n[11:0]}; bit i = slot i
    localparam int NROWS = 16;
    localparam logic [27:0] VEC [NROWS] = '{
        {4'b0000, 12'h0C3, 12'hFFF},  // R1 R3 internal fetch
        {4'b0010, 12'h0C3, 12'h1C7},  // R2 external fetch
        {4'b1010, 12'h0C3, 12'h1C7},  // R4 access first cycle
        {4'b0010, 12'h0C0, 12'hFFF},  // R5 access second cycle
        {4'b0011, 12'h0C3, 12'h1C7},  // R7 disable bit ignored
        {4'b0001, 12'hFFF, 12'hFFF},  // R6 parked high
        {4'b0101, 12'h0C3, 12'hFFF},  // R6 code-table read
        {4'b1001, 12'h0C3, 12'hFFF},  // R6 data access first cycle
        {4'b0001, 12'h0C0, 12'hFFF},  // R6 R5 data access second cycle
        {4'b1010, 12'h0C3, 12'h1C7},  // R5 back-to-back access
        {4'b1010, 12'h0C0, 12'hFFF},  // R5 request in second cycle ignored
        {4'b0010, 12'h0C3, 12'h1C7},  // R5 return to fetch
        {4'b0000, 12'h0C3, 12'hFFF},  // R3 internal fetch
        {4'b1000, 12'h0C3, 12'hFFF},  // R4 internal access
        {4'b0000, 12'h0C0, 12'hFFF},  // R5 internal second cycle
        {4'b0001, 12'hFFF, 12'hFFF}   // R6 parked again
    };

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    // Starts at a falling edge inside slot 11; ends at the falling edge in the next slot 11
    task automatic run_row(input logic [27:0] v, input string tag,
                           input bit mid, input logic [3:0] midv);
        logic [11:0] cap_ale;
        logic [11:0] cap_ps;
        logic [11:0] cap_sync;
        {xdata_req, code_rd, ext_exec, ale_off} = v[27:24];
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            cap_ale[i]  = ale;
            cap_ps[i]   = psen_n;
            cap_sync[i] = mc_sync;
            if (mid && i == 3) {xdata_req, code_rd, ext_exec, ale_off} = midv;
        end
        check({tag, " ale"}, cap_ale, v[23:12]);
        check({tag, " psen_n"}, cap_ps, v[11:0]);
        check("R10 mc_sync", cap_sync, 12'h800);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset outputs", {9'd0, ale, psen_n, mc_sync}, 12'h003);
        rst_n = 1'b1;

        for (int r = 0; r < NROWS; r++) begin
            run_row(VEC[r], $sformatf("row%0d", r), 1'b0, 4'b0000);
        end

        // R8: mid-cycle changes have no effect on this cycle or on the next cycle's type
        run_row({4'b0010, 12'h0C3, 12'h1C7}, "R8 mid-cycle change", 1'b1, 4'b1001);
        run_row({4'b0000, 12'h0C3, 12'hFFF}, "R8 next cycle plain fetch", 1'b0, 4'b0000);

        // R9: reset inside a second access cycle, then a fetch cycle follows
        run_row({4'b1010, 12'h0C3, 12'h1C7}, "R4 before reset", 1'b0, 4'b0000);
        xdata_req = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid-cycle reset", {9'd0, ale, psen_n, mc_sync}, 12'h003);
        rst_n = 1'b1;
        run_row({4'b0010, 12'h0C3, 12'h1C7}, "R9 fetch after reset", 1'b0, 4'b0000);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule